// File: doc/BRIEF.md
# Trap Entry and Mode Transfer Unit

This unit performs the hardware half of a change of privilege on a small processor core. It holds the privilege mode bit (0 means kernel, 1 means user) and the interrupt-enable flag. It accepts synchronous exceptions, system calls, a maskable interrupt and a non-maskable interrupt. An instruction marked privileged that is issued in user mode is turned into an exception. Only one request is taken at a time.

When a trap is taken, the unit saves the current mode and enable flag, enters kernel mode and masks interrupts. It then switches to the kernel stack and pushes three words, one per cycle, toward lower addresses: the interrupted SP, the interrupted PC and an error code. Next it reads the handler address from a 256-entry vector table and redirects the core. A return command, issued in kernel mode, reads the saved PC and SP words back from the current stack. It then restores the mode, the enable flag, PC and SP. While either sequence runs, `busy` stalls the core.

The kernel stack pointer, the vector base and the enable flag are privileged settings. They can be written only in kernel mode while the unit is idle. Stack and table traffic uses a single-port memory interface: writes take effect at the clock edge, and read data returns one cycle after the request.

Top module: `trap_unit`

## Requirements
- R1: After a synchronous active-low reset, `priv_mode` is 0 (kernel), `int_en` is 0 and `busy`, `redirect`, `mem_we` and `mem_re` are 0.
- R2: An issued instruction with `issue_priv` set while `priv_mode` is 1 asserts `insn_kill` in that cycle and takes an exception trap with vector 0x0D. The same instruction in kernel mode neither kills nor traps.
- R3: From the cycle after a trap is accepted, `priv_mode` and `int_en` read 0. `busy` stays high for exactly five cycles, and `redirect` rises in the fifth.
- R4: In the first three busy cycles of an entry, the unit writes, in this order, the SP word at K-4, the PC word at K-8 and the error word at K-12, where K is the kernel stack setting. The SP and PC words hold bits [31:2] of the interrupted value. Each of the three words carries the previous enable flag in bit 1 and the previous mode in bit 0. The error word holds the class in bits [11:10] and the vector in bits [9:2], with zeros above. The class encoding is 0 for exception, 1 for system call, 2 for interrupt and 3 for non-maskable interrupt.
- R5: At `redirect` of an entry, `pc_out` equals the word read from vector base + 4 × vector and `sp_out` equals K-12. The vectors are: `exc_code` for an exception, 0x30 for a system call, 0x02 for the non-maskable interrupt and `irq_code` for an interrupt.
- R6: When requests coincide, the order of precedence is: exception request, then privilege violation, then system call, then return, then non-maskable interrupt, then maskable interrupt.
- R7: `irq_req` is ignored while `int_en` is 0. A rising edge on `nmi_in` is remembered and taken in the following idle cycle, whatever the enable flag.
- R8: A return accepted in kernel mode reads the PC word at S+4 and the SP word at S+8, where S is `cur_sp`. In the third cycle after acceptance it asserts `redirect`, with `pc_out` and `sp_out` equal to those words with bits [1:0] cleared. In the cycle after that, `priv_mode` and `int_en` take bits 0 and 1 of the PC word.
- R9: A return request in user mode asserts `insn_kill` and takes an exception trap with vector 0x0D.
- R10: Configuration writes use `cfg_sel` 0 for the kernel stack, 1 for the vector base and 2 for the enable flag (bit 0). These writes are ignored in user mode.
- R11: Trap and return requests that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| issue_priv | input | 1 | The issued instruction is privileged |
| exc_req | input | 1 | Synchronous exception request |
| exc_code | input | 8 | Vector number of the exception |
| sys_req | input | 1 | System call request |
| irq_req | input | 1 | Maskable interrupt request, already prioritised |
| irq_code | input | 8 | Vector number of the interrupt |
| nmi_in | input | 1 | Non-maskable interrupt, edge sensitive |
| rti_req | input | 1 | Return-from-trap command |
| cur_pc | input | 32 | PC of the interrupted instruction |
| cur_sp | input | 32 | Current stack pointer |
| cfg_we | input | 1 | Privileged setting write strobe |
| cfg_sel | input | 2 | Setting select |
| cfg_wdata | input | 32 | Setting write data |
| mem_we | output | 1 | Stack push write strobe |
| mem_re | output | 1 | Stack or vector read strobe |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Word pushed |
| mem_rdata | input | 32 | Read data, one cycle after `mem_re` |
| busy | output | 1 | Sequence in progress, core stalled |
| insn_kill | output | 1 | Issued instruction must not complete |
| redirect | output | 1 | Load `pc_out` and `sp_out` this cycle |
| pc_out | output | 32 | New PC |
| sp_out | output | 32 | New SP |
| priv_mode | output | 1 | Mode bit, 0 kernel, 1 user |
| int_en | output | 1 | Maskable interrupt enable |

## Verification
A corrupted saved mode or enable flag shows up in bits [1:0] of the pushed words within three cycles of acceptance. After the matching return, it shows up again as a wrong `priv_mode` or `int_en`. A wrong latched cause or arbitration choice appears five cycles after acceptance as a wrong `pc_out`, and earlier than that as a wrong error word. A stuck or mis-sequenced state register changes the `redirect` latency, or shifts the stack address one word. Either is visible within the same sequence.

// File: rtl/trap_pkg.sv
// Shared types of the trap entry unit: trap classes and sequencer states.
// Assumes class codes are stored in the pushed error word, so the encoding is fixed.
package trap_pkg;
    typedef enum logic [1:0] {
        CLS_EXC = 2'd0,
        CLS_SYS = 2'd1,
        CLS_IRQ = 2'd2,
        CLS_NMI = 2'd3
    } trap_cls_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_SP,
        ST_PUSH_PC,
        ST_PUSH_ERR,
        ST_FETCH,
        ST_VECTOR,
        ST_POP_PC,
        ST_POP_SP,
        ST_RESUME
    } seq_state_e;
endpackage

// File: rtl/trap_arbiter.sv
// Chooses which request, if any, the unit accepts in an idle cycle.
// Assumes all inputs are stable for the cycle; the clock is used only by checks.
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] SYS_VEC  = 'h30,
    parameter logic [VEC_W-1:0] PRIV_VEC = 'h0D,
    parameter logic [VEC_W-1:0] NMI_VEC  = 'h02
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             mode,
    input  logic             ie,
    input  logic             issue_valid,
    input  logic             issue_priv,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_code,
    input  logic             sys_req,
    input  logic             rti_req,
    input  logic             nmi_pend,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_code,
    output logic             take,
    output trap_cls_e        take_cls,
    output logic [VEC_W-1:0] take_vec,
    output logic             rti_go,
    output logic             insn_kill
);
    logic priv_viol;

    // Privileged work attempted from user mode, either an instruction or a return.
    assign priv_viol = mode & ((issue_valid & issue_priv) | rti_req);
    assign insn_kill = idle & priv_viol;

    // Fixed-precedence selection: synchronous sources before asynchronous ones.
    always_comb begin
        take     = 1'b0;
        rti_go   = 1'b0;
        take_cls = CLS_EXC;
        take_vec = '0;
        if (idle) begin
            if (exc_req) begin
                take     = 1'b1;
                take_vec = exc_code;
            end else if (priv_viol) begin
                take     = 1'b1;
                take_vec = PRIV_VEC;
            end else if (sys_req) begin
                take     = 1'b1;
                take_cls = CLS_SYS;
                take_vec = SYS_VEC;
            end else if (rti_req) begin
                rti_go   = 1'b1;
            end else if (nmi_pend) begin
                take     = 1'b1;
                take_cls = CLS_NMI;
                take_vec = NMI_VEC;
            end else if (irq_req && ie) begin
                take     = 1'b1;
                take_cls = CLS_IRQ;
                take_vec = irq_code;
            end
        end
    end

    // R6
    exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && exc_req) |-> (take && take_cls == CLS_EXC && take_vec == exc_code));
    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_cls == CLS_IRQ) |-> ie);
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> (!take && !rti_go && !insn_kill));
endmodule

// File: rtl/trap_csr.sv
// Privileged settings: kernel stack pointer and vector table base, plus the
// enable-flag write strobe. Assumes writes come only from kernel-mode code.
module trap_csr #(
    parameter int XLEN = 32,
    parameter logic [XLEN-1:0] KSP_RST   = '0,
    parameter logic [XLEN-1:0] VBASE_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode,
    input  logic            idle,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [XLEN-1:0] cfg_wdata,
    output logic [XLEN-1:0] ksp,
    output logic [XLEN-1:0] vbase,
    output logic            ie_wr,
    output logic            ie_wdata
);
    logic wr_ok;

    assign wr_ok    = cfg_we & ~mode & idle;
    assign ie_wr    = wr_ok && (cfg_sel == 2'd2);
    assign ie_wdata = cfg_wdata[0];

    // Setting registers, writable only in kernel mode while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ksp   <= KSP_RST;
            vbase <= VBASE_RST;
        end else if (wr_ok) begin
            if (cfg_sel == 2'd0) ksp   <= cfg_wdata;
            if (cfg_sel == 2'd1) vbase <= cfg_wdata;
        end
    end

    // R10
    user_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode |=> ($stable(ksp) && $stable(vbase)));
endmodule

// File: rtl/trap_seq.sv
// Entry and return sequencer: owns the mode bit, enable flag, pending
// non-maskable flag and the stack push / pop / vector fetch order.
// Assumes memory read data arrives one cycle after mem_re.
module trap_seq
    import trap_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  trap_cls_e        take_cls,
    input  logic [VEC_W-1:0] take_vec,
    input  logic             rti_go,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [XLEN-1:0]  ksp,
    input  logic [XLEN-1:0]  vbase,
    input  logic             ie_wr,
    input  logic             ie_wdata,
    input  logic             nmi_in,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             mem_we,
    output logic             mem_re,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             idle,
    output logic             busy,
    output logic             redirect,
    output logic [XLEN-1:0]  pc_out,
    output logic [XLEN-1:0]  sp_out,
    output logic             mode,
    output logic             ie,
    output logic             nmi_pend
);
    localparam int PAD = XLEN - VEC_W - 4;

    seq_state_e       state;
    logic             sv_mode, sv_ie, nmi_q;
    logic [XLEN-3:0]  sv_sp, sv_pc;
    trap_cls_e        sv_cls;
    logic [VEC_W-1:0] sv_vec;
    logic [XLEN-1:0]  frame, pc_word, vec_off;
    logic [1:0]       flags;
    logic             unused_low;

    assign unused_low = ^{cur_pc[1:0], cur_sp[1:0]};
    assign idle     = (state == ST_IDLE);
    assign busy     = !idle;
    assign flags    = {sv_ie, sv_mode};
    assign vec_off  = {{(XLEN-VEC_W-2){1'b0}}, sv_vec, 2'b00};
    assign redirect = (state == ST_VECTOR) || (state == ST_RESUME);

    // Memory request per state: pushes grow downward, pops read upward.
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_SP:  begin mem_we = 1'b1; mem_addr = frame - XLEN'(4);  mem_wdata = {sv_sp, flags}; end
            ST_PUSH_PC:  begin mem_we = 1'b1; mem_addr = frame - XLEN'(8);  mem_wdata = {sv_pc, flags}; end
            ST_PUSH_ERR: begin
                mem_we    = 1'b1;
                mem_addr  = frame - XLEN'(12);
                mem_wdata = {{PAD{1'b0}}, sv_cls, sv_vec, flags};
            end
            ST_FETCH:    begin mem_re = 1'b1; mem_addr = vbase + vec_off; end
            ST_POP_PC:   begin mem_re = 1'b1; mem_addr = frame + XLEN'(4); end
            ST_POP_SP:   begin mem_re = 1'b1; mem_addr = frame + XLEN'(8); end
            default: ;
        endcase
    end

    // Redirect values: handler address on entry, restored frame on return.
    always_comb begin
        pc_out = '0;
        sp_out = '0;
        if (state == ST_VECTOR) begin
            pc_out = mem_rdata;
            sp_out = frame - XLEN'(12);
        end else if (state == ST_RESUME) begin
            pc_out = {pc_word[XLEN-1:2], 2'b00};
            sp_out = {mem_rdata[XLEN-1:2], 2'b00};
        end
    end

    // Non-maskable request edge capture, cleared when that trap is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            if (nmi_in && !nmi_q)                    nmi_pend <= 1'b1;
            else if (take && take_cls == CLS_NMI)    nmi_pend <= 1'b0;
        end
    end

    // Sequencer state, saved context and the mode / enable flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mode    <= 1'b0;
            ie      <= 1'b0;
            sv_mode <= 1'b0;
            sv_ie   <= 1'b0;
            sv_sp   <= '0;
            sv_pc   <= '0;
            sv_cls  <= CLS_EXC;
            sv_vec  <= '0;
            frame   <= '0;
            pc_word <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        sv_mode <= mode;
                        sv_ie   <= ie;
                        mode    <= 1'b0;
                        ie      <= 1'b0;
                        sv_sp   <= cur_sp[XLEN-1:2];
                        sv_pc   <= cur_pc[XLEN-1:2];
                        sv_cls  <= take_cls;
                        sv_vec  <= take_vec;
                        frame   <= ksp;
                        state   <= ST_PUSH_SP;
                    end else if (rti_go) begin
                        frame   <= cur_sp;
                        state   <= ST_POP_PC;
                    end else if (ie_wr) begin
                        ie      <= ie_wdata;
                    end
                end
                ST_PUSH_SP:  state <= ST_PUSH_PC;
                ST_PUSH_PC:  state <= ST_PUSH_ERR;
                ST_PUSH_ERR: state <= ST_FETCH;
                ST_FETCH:    state <= ST_VECTOR;
                ST_VECTOR:   state <= ST_IDLE;
                ST_POP_PC:   state <= ST_POP_SP;
                ST_POP_SP: begin
                    pc_word <= mem_rdata;
                    state   <= ST_RESUME;
                end
                ST_RESUME: begin
                    mode  <= pc_word[0];
                    ie    <= pc_word[1];
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    kernel_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!mode && !ie));
    // R4
    push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PUSH_SP) |=> (mem_we && mem_addr == frame - XLEN'(8)));
    // R4
    push_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> busy);
    // R8
    redirect_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !busy);
endmodule

// File: rtl/trap_unit.sv
// Top of the trap entry and mode transfer unit: arbiter, privileged settings
// and sequencer. Assumes the core stalls while busy and holds level requests.
module trap_unit
    import trap_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] SYS_VEC  = 'h30,
    parameter logic [VEC_W-1:0] PRIV_VEC = 'h0D,
    parameter logic [VEC_W-1:0] NMI_VEC  = 'h02,
    parameter logic [XLEN-1:0]  KSP_RST   = '0,
    parameter logic [XLEN-1:0]  VBASE_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic             issue_priv,
    input  logic             exc_req,
    input  logic [VEC_W-1:0] exc_code,
    input  logic             sys_req,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_code,
    input  logic             nmi_in,
    input  logic             rti_req,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [XLEN-1:0]  cfg_wdata,
    output logic             mem_we,
    output logic             mem_re,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             insn_kill,
    output logic             redirect,
    output logic [XLEN-1:0]  pc_out,
    output logic [XLEN-1:0]  sp_out,
    output logic             priv_mode,
    output logic             int_en
);
    logic             idle, take, rti_go, nmi_pend, ie_wr, ie_wdata;
    trap_cls_e        take_cls;
    logic [VEC_W-1:0] take_vec;
    logic [XLEN-1:0]  ksp, vbase;

    trap_arbiter #(
        .VEC_W(VEC_W), .SYS_VEC(SYS_VEC), .PRIV_VEC(PRIV_VEC), .NMI_VEC(NMI_VEC)
    ) i_arb (
        .clk(clk), .rst_n(rst_n), .idle(idle), .mode(priv_mode), .ie(int_en),
        .issue_valid(issue_valid), .issue_priv(issue_priv),
        .exc_req(exc_req), .exc_code(exc_code), .sys_req(sys_req),
        .rti_req(rti_req), .nmi_pend(nmi_pend), .irq_req(irq_req),
        .irq_code(irq_code), .take(take), .take_cls(take_cls),
        .take_vec(take_vec), .rti_go(rti_go), .insn_kill(insn_kill)
    );

    trap_csr #(
        .XLEN(XLEN), .KSP_RST(KSP_RST), .VBASE_RST(VBASE_RST)
    ) i_csr (
        .clk(clk), .rst_n(rst_n), .mode(priv_mode), .idle(idle),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ksp(ksp), .vbase(vbase), .ie_wr(ie_wr), .ie_wdata(ie_wdata)
    );

    trap_seq #(
        .XLEN(XLEN), .VEC_W(VEC_W)
    ) i_seq (
        .clk(clk), .rst_n(rst_n), .take(take), .take_cls(take_cls),
        .take_vec(take_vec), .rti_go(rti_go), .cur_pc(cur_pc), .cur_sp(cur_sp),
        .ksp(ksp), .vbase(vbase), .ie_wr(ie_wr), .ie_wdata(ie_wdata),
        .nmi_in(nmi_in), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .idle(idle), .busy(busy), .redirect(redirect), .pc_out(pc_out),
        .sp_out(sp_out), .mode(priv_mode), .ie(int_en), .nmi_pend(nmi_pend)
    );
endmodule

// File: tb/test_trap_unit.sv
module test_trap_unit;
    localparam logic [31:0] KSP   = 32'h0000_0400;
    localparam logic [31:0] VBASE = 32'h0000_0800;
    localparam logic [31:0] FRAME = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid, issue_priv, exc_req, sys_req, irq_req, nmi_in, rti_req;
    logic [7:0]  exc_code, irq_code;
    logic [31:0] cur_pc, cur_sp, cfg_wdata;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic        mem_we, mem_re, busy, insn_kill, redirect, priv_mode, int_en;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_out, sp_out;

    logic [31:0] mem [0:1023];
    logic        tb_we;
    logic [9:0]  tb_idx;
    logic [31:0] tb_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trap_unit i_trap_unit (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_priv(issue_priv),
        .exc_req(exc_req), .exc_code(exc_code), .sys_req(sys_req), .irq_req(irq_req),
        .irq_code(irq_code), .nmi_in(nmi_in), .rti_req(rti_req), .cur_pc(cur_pc),
        .cur_sp(cur_sp), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .insn_kill(insn_kill), .redirect(redirect),
        .pc_out(pc_out), .sp_out(sp_out), .priv_mode(priv_mode), .int_en(int_en)
    );

    function automatic logic [31:0] handler(input logic [7:0] v);
        return 32'h1000_0000 | {20'd0, v, 4'h0};
    endfunction

    // Memory model: stack RAM below VBASE, computed vector table above it.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else if (tb_we) mem[tb_idx] <= tb_data;
        if (mem_re)
            mem_rdata <= (mem_addr >= VBASE) ? handler(8'((mem_addr - VBASE) >> 2)) : mem[mem_addr[11:2]];
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] data);
        tb_we = 1'b1; tb_idx = addr[11:2]; tb_data = data;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Return from kernel into a prepared frame; checks R8.
    task automatic go_user(input logic [31:0] pc, input logic [31:0] sp, input logic ie_v);
        int lat;
        poke(FRAME + 4, {pc[31:2], ie_v, 1'b1});
        poke(FRAME + 8, {sp[31:2], ie_v, 1'b0});
        rti_req = 1'b1; cur_sp = FRAME;
        @(negedge clk);
        rti_req = 1'b0;
        lat = 1;
        while (!redirect && lat < 10) begin @(negedge clk); lat++; end
        check("R8 return latency", lat, 3);
        check("R8 restored pc", pc_out, {pc[31:2], 2'b00});
        check("R8 restored sp", sp_out, {sp[31:2], 2'b00});
        @(negedge clk);
        check("R8 restored mode/ie", {30'd0, int_en, priv_mode}, {30'd0, ie_v, 1'b1});
    endtask

    // Drive one request set; returns whether a trap was expected and checked.
    task automatic do_trap(input string tag, input logic e, input logic [7:0] ec,
                           input logic p, input logic s, input logic r, input logic i,
                           input logic [7:0] ic, input logic [31:0] pc, input logic [31:0] sp,
                           input logic [31:0] kspv, output bit took);
        logic        um, uie;
        logic [1:0]  cls;
        logic [7:0]  vec;
        int          lat;
        um = priv_mode; uie = int_en;
        took = 1'b1;
        if (e)               begin cls = 2'd0; vec = ec;    end
        else if ((p || r) && um) begin cls = 2'd0; vec = 8'h0D; end
        else if (s)          begin cls = 2'd1; vec = 8'h30; end
        else if (i && uie)   begin cls = 2'd2; vec = ic;    end
        else                 begin cls = 2'd0; vec = 8'h00; took = 1'b0; end
        exc_req = e; exc_code = ec; issue_valid = p; issue_priv = p; sys_req = s;
        rti_req = r; irq_req = i; irq_code = ic; cur_pc = pc; cur_sp = sp;
        #1;
        check({tag, " R2 kill"}, {31'd0, insn_kill}, {31'd0, um & (p | r)});
        @(negedge clk);
        exc_req = 0; issue_valid = 0; issue_priv = 0; sys_req = 0; rti_req = 0; irq_req = 0;
        if (!took) begin
            check({tag, " R7 no trap"}, {31'd0, busy}, 32'd0);
            return;
        end
        check({tag, " R3 masked kernel"}, {29'd0, busy, int_en, priv_mode}, 32'd4);
        lat = 1;
        while (!redirect && lat < 10) begin @(negedge clk); lat++; end
        check({tag, " R3 entry latency"}, lat, 5);
        check({tag, " R5 handler pc"}, pc_out, handler(vec));
        check({tag, " R5 kernel sp"}, sp_out, kspv - 12);
        @(negedge clk);
        check({tag, " R3 done"}, {30'd0, busy, priv_mode}, 32'd0);
        check({tag, " R4 sp word"}, mem[(kspv - 4) >> 2], {sp[31:2], uie, um});
        check({tag, " R4 pc word"}, mem[(kspv - 8) >> 2], {pc[31:2], uie, um});
        check({tag, " R4 err word"}, mem[(kspv - 12) >> 2], {20'd0, cls, vec, uie, um});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; issue_valid = 0; issue_priv = 0; exc_req = 0; sys_req = 0; irq_req = 0;
        nmi_in = 0; rti_req = 0; exc_code = 0; irq_code = 0; cur_pc = 0; cur_sp = 0;
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; tb_we = 0; tb_idx = 0; tb_data = 0;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {26'd0, priv_mode, int_en, busy, redirect, mem_we, mem_re}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        cfg(2'd0, KSP);
        cfg(2'd1, VBASE);
        begin : directed
            bit t;
            // R2: privileged instruction in kernel mode completes.
            issue_valid = 1; issue_priv = 1;
            #1 check("R2 kernel no kill", {31'd0, insn_kill}, 32'd0);
            @(negedge clk);
            issue_valid = 0; issue_priv = 0;
            check("R2 kernel no trap", {31'd0, busy}, 32'd0);
            // R2: in user mode it traps.
            go_user(32'h0000_4444, 32'h0000_7770, 1'b1);
            do_trap("priv", 0, 0, 1, 0, 0, 0, 0, 32'h0000_4444, 32'h0000_7770, KSP, t);
            // R9: return from user mode.
            go_user(32'h0000_5550, 32'h0000_6660, 1'b0);
            do_trap("R9 rti user", 0, 0, 0, 0, 1, 0, 0, 32'h0000_5550, 32'h0000_6660, KSP, t);
            // R6: all sources together, exception wins.
            go_user(32'h0000_1230, 32'h0000_2340, 1'b1);
            do_trap("R6 all", 1, 8'hFF, 1, 1, 0, 1, 8'h41, 32'h0000_1230, 32'h0000_2340, KSP, t);
            // R6: privilege violation over system call.
            go_user(32'h0000_1230, 32'h0000_2340, 1'b1);
            do_trap("R6 priv>sys", 0, 0, 1, 1, 0, 1, 8'h41, 32'h0000_1230, 32'h0000_2340, KSP, t);
            // R7: masked interrupt ignored, then system call recovers.
            go_user(32'h0000_3330, 32'h0000_3440, 1'b0);
            do_trap("R7 masked", 0, 0, 0, 0, 0, 1, 8'h50, 32'h0000_3330, 32'h0000_3440, KSP, t);
            check("R7 still user", {31'd0, priv_mode}, 32'd1);
            // R10: user-mode write to the kernel stack setting has no effect.
            cfg(2'd0, 32'h0000_0200);
            do_trap("R10 user cfg", 0, 0, 0, 1, 0, 0, 0, 32'h0000_3330, 32'h0000_3440, KSP, t);
            // R10: kernel-mode write takes effect.
            cfg(2'd0, 32'h0000_0300);
            go_user(32'h0000_3330, 32'h0000_3440, 1'b1);
            do_trap("R10 kernel cfg", 0, 0, 0, 0, 0, 1, 8'h33, 32'h0000_3330, 32'h0000_3440, 32'h0000_0300, t);
            cfg(2'd0, KSP);
            // R10: enable flag written in kernel mode.
            cfg(2'd2, 32'd1);
            check("R10 ie write", {31'd0, int_en}, 32'd1);
            cfg(2'd2, 32'd0);
            // R7: non-maskable edge taken with interrupts masked.
            go_user(32'h0000_8880, 32'h0000_9990, 1'b0);
            begin : nmi_case
                int lat;
                cur_pc = 32'h0000_8880; cur_sp = 32'h0000_9990;
                nmi_in = 1;
                @(negedge clk);
                nmi_in = 0;
                lat = 1;
                while (!redirect && lat < 12) begin @(negedge clk); lat++; end
                check("R7 nmi latency", lat, 6);
                check("R7 nmi vector", pc_out, handler(8'h02));
                @(negedge clk);
                check("R7 nmi err word", mem[(KSP - 12) >> 2], {20'd0, 2'd3, 8'h02, 1'b0, 1'b1});
            end
            // R11: requests while busy are ignored.
            go_user(32'h0000_AAA0, 32'h0000_BBB0, 1'b1);
            begin : busy_case
                int lat;
                sys_req = 1; cur_pc = 32'h0000_AAA0; cur_sp = 32'h0000_BBB0;
                @(negedge clk);
                sys_req = 0;
                @(negedge clk);
                exc_req = 1; exc_code = 8'h07; irq_req = 1; irq_code = 8'h60;
                @(negedge clk);
                @(negedge clk);
                exc_req = 0; irq_req = 0;
                lat = 3;
                while (!redirect && lat < 10) begin @(negedge clk); lat++; end
                check("R11 first trap kept", pc_out, handler(8'h30));
                @(negedge clk);
                check("R11 no second trap", {31'd0, busy}, 32'd0);
                @(negedge clk);
                check("R11 still idle", {31'd0, busy}, 32'd0);
            end
        end
        // Random mix of sources and contexts.
        for (int k = 0; k < 40; k++) begin
            logic [31:0] rpc, rsp;
            logic        rie;
            bit          t;
            rpc = $urandom(); rpc[1:0] = 2'b00;
            rsp = $urandom(); rsp[1:0] = 2'b00;
            rie = ($urandom() % 4) != 0;
            go_user(rpc, rsp, rie);
            do_trap("rand", ($urandom() % 4) == 0, 8'($urandom()), ($urandom() % 3) == 0,
                    ($urandom() % 3) == 0, 1'b0, ($urandom() % 2) == 0, 8'($urandom()),
                    rpc, rsp, KSP, t);
            if (!t) do_trap("rand sys", 0, 0, 0, 1, 0, 0, 0, rpc, rsp, KSP, t);
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule